// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each incoming Ethernet frame, whether its destination MAC address is wanted. A parser upstream presents the 48-bit destination with a one-cycle strobe. The filter compares that address in parallel against a table of programmable station addresses. It then combines the table outcome with three category rules: broadcast, group (multicast) and individual (unicast). One clock later it returns an accept flag and the index of the first table entry that hit.

Software configures the filter through a simple write-only port. Through it, software sets a control word, a per-entry enable mask and two words per table entry. The table result can be switched off altogether, or inverted so that the table acts as a block list instead of a pass list. Frame parsing, CRC checking and the DMA that moves accepted frames happen elsewhere.

Top module: `rx_dst_filter`

## Requirements
- R1: While and directly after reset, `dec_valid` and `dec_accept` are 0, `dec_index` is all ones, and the control word and entry-enable mask are 0.
- R2: Write index 0 loads the control word and index 1 loads the entry-enable mask (bit k enables entry k). Index 2+2k loads entry k's first word, which holds destination bytes 0..3 with byte 0 (first on the wire) in bits 31:24. Index 3+2k loads bits 31:16 of entry k's second word, which hold bytes 4..5. Bits 15:0 of that second word are ignored, and so are writes to indices above 1+2·ENTRIES.
- R3: With control bit 0 (table enable) set and control bit 1 (invert) clear, a destination equal to an enabled entry is accepted. A destination that matches no enabled entry and is not accepted by a category rule is rejected.
- R4: An entry whose enable-mask bit is 0 never matches, even when its stored address equals the destination.
- R5: With the table enable bit clear, the table never causes acceptance, whether or not invert is set, and `dec_index` is all ones.
- R6: With table enable and invert both set, a destination that matches no enabled entry is accepted. A matching destination is accepted only through a category rule, and `dec_index` still reports the matching entry.
- R7: With control bit 2 set, the all-ones destination is accepted regardless of the table.
- R8: With control bit 3 set, any destination whose group bit (bit 0 of byte 0, which is `dst_addr[40]`) is 1 is accepted.
- R9: With control bit 4 set, any destination whose group bit is 0 is accepted.
- R10: `dec_valid` is high exactly in the cycle after an `addr_valid` cycle. `dec_accept` and `dec_index` change only in that cycle and hold otherwise.
- R11: When the table is enabled and one or more enabled entries match, `dec_index` is the lowest matching index. When no enabled entry matches, it is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | REG_AW | Configuration word index |
| cfg_wr_data | input | 32 | Configuration write data |
| addr_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination MAC, byte 0 in bits 47:40 |
| dec_valid | output | 1 | Decision valid, one cycle after the strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_index | output | IDX_W | Lowest matching entry, all ones if none |

## Verification
The in-module properties check, on every cycle, the one-cycle latency and hold of the decision and that a disabled entry never raises a hit. They also check that each category rule forces acceptance, that a disabled table yields the all-ones index, and that a plain miss is rejected. Only the bench scenarios can show that the write map places each byte where it belongs and that the unused low half and out-of-range writes leave matching unchanged. The same holds for lowest-index selection among duplicate entries and for the full interplay of invert with every control combination.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;
  localparam int MAC_W     = 48;
  localparam int GROUP_BIT = 40;
  localparam int CTRL_W    = 5;
  localparam int TBL_BASE  = 2;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic ucast;     // bit 4
    logic mcast;     // bit 3
    logic bcast;     // bit 2
    logic invert;    // bit 1
    logic table_en;  // bit 0
  } filt_ctrl_t;
endpackage

// File: rtl/filt_cfg_regs.sv
module filt_cfg_regs
  import dst_filt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int REG_AW  = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [REG_AW-1:0]                 wr_idx,
  input  logic [31:0]                       wr_data,
  output filt_ctrl_t                        ctrl,
  output logic [ENTRIES-1:0]                entry_en,
  output logic [ENTRIES-1:0][MAC_W-1:0]     entry_addr
);
  localparam int HI_W = 32;
  localparam int LO_W = MAC_W - HI_W;

  logic [HI_W-1:0] hi_q [ENTRIES];
  logic [LO_W-1:0] lo_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      entry_en <= '0;
    end else if (wr_en) begin
      if (wr_idx == REG_AW'(0)) ctrl     <= filt_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_idx == REG_AW'(1)) entry_en <= wr_data[ENTRIES-1:0];
    end
  end

  // table words carry no reset; entries are gated by entry_en
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (wr_en && wr_idx == REG_AW'(TBL_BASE + 2*e))
        hi_q[e] <= wr_data;
      if (wr_en && wr_idx == REG_AW'(TBL_BASE + 2*e + 1))
        lo_q[e] <= wr_data[31 -: LO_W];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pack
    assign entry_addr[g] = {hi_q[g], lo_q[g]};
  end
endmodule

// File: rtl/filt_cam_compare.sv
module filt_cam_compare
  import dst_filt_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0][MAC_W-1:0] entry_addr,
  input  logic [ENTRIES-1:0]            entry_en,
  input  logic [MAC_W-1:0]              probe,
  output logic [ENTRIES-1:0]            hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = entry_en[g] && (entry_addr[g] == probe);
  end
endmodule

// File: rtl/filt_first_hit.sv
module filt_first_hit #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0] hit,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter
  import dst_filt_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int REG_AW  = $clog2(TBL_BASE + 2*ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [REG_AW-1:0] cfg_wr_idx,
  input  logic [31:0]       cfg_wr_data,
  input  logic              addr_valid,
  input  logic [MAC_W-1:0]  dst_addr,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [IDX_W-1:0]  dec_index
);
  filt_ctrl_t                      ctrl;
  logic [ENTRIES-1:0]              entry_en;
  logic [ENTRIES-1:0][MAC_W-1:0]   entry_addr;
  logic [ENTRIES-1:0]              hit;
  logic                            any_hit;
  logic [IDX_W-1:0]                first_idx;

  filt_cfg_regs #(.ENTRIES(ENTRIES), .REG_AW(REG_AW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr_en),
    .wr_idx     (cfg_wr_idx),
    .wr_data    (cfg_wr_data),
    .ctrl       (ctrl),
    .entry_en   (entry_en),
    .entry_addr (entry_addr)
  );

  filt_cam_compare #(.ENTRIES(ENTRIES)) u_cmp (
    .entry_addr (entry_addr),
    .entry_en   (entry_en),
    .probe      (dst_addr),
    .hit        (hit)
  );

  filt_first_hit #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_enc (
    .hit (hit),
    .any (any_hit),
    .idx (first_idx)
  );

  logic is_bcast, is_group, tbl_ok, cat_ok, accept_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    is_bcast = &dst_addr;
    is_group = dst_addr[GROUP_BIT];
    tbl_ok   = ctrl.table_en && (any_hit ^ ctrl.invert);
    cat_ok   = (ctrl.bcast && is_bcast) || (ctrl.mcast && is_group) ||
               (ctrl.ucast && !is_group);
    accept_d = tbl_ok || cat_ok;
    idx_d    = (ctrl.table_en && any_hit) ? first_idx : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_index  <= '1;
    end else begin
      dec_valid <= addr_valid;
      if (addr_valid) begin
        dec_accept <= accept_d;
        dec_index  <= idx_d;
      end
    end
  end

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> dec_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> !dec_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> ($stable(dec_accept) && $stable(dec_index)));
  p_disabled_no_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (hit & ~entry_en) == '0);
  p_bcast_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && ctrl.bcast && (&dst_addr)) |=> dec_accept);
  p_mcast_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && ctrl.mcast && dst_addr[GROUP_BIT]) |=> dec_accept);
  p_ucast_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && ctrl.ucast && !dst_addr[GROUP_BIT]) |=> dec_accept);
  p_table_off_idx_r5: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !ctrl.table_en) |=> (dec_index == '1));
  p_miss_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !ctrl.invert && hit == '0 && !ctrl.bcast &&
     !ctrl.mcast && !ctrl.ucast) |=> !dec_accept);
endmodule

// File: tb/tb_rx_dst_filter.sv
module tb_rx_dst_filter;
  localparam int N     = 16;
  localparam int IDX_W = 4;
  localparam int RAW   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr_en = 1'b0;
  logic [RAW-1:0] cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic addr_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic dec_valid, dec_accept;
  logic [IDX_W-1:0] dec_index;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [47:0] m_addr [N];
  logic [15:0] m_en;
  logic [4:0]  m_ctl;

  always #4 clk = ~clk;

  rx_dst_filter #(.ENTRIES(N)) dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .addr_valid(addr_valid), .dst_addr(dst_addr),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_index(dec_index)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] addr_of(input int i);
    if (i == 12) return addr_of(5);
    return {8'h02, 8'hA0, 8'h00, 8'(i), 8'h5E, 8'(i * 3)};
  endfunction

  function automatic logic [IDX_W-1:0] exp_idx(input logic [47:0] a);
    if (!m_ctl[0]) return '1;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_addr[i] == a) return IDX_W'(i);
    return '1;
  endfunction

  function automatic logic exp_acc(input logic [47:0] a);
    logic hitany, tbl, cat;
    hitany = 1'b0;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_addr[i] == a) hitany = 1'b1;
    tbl = m_ctl[0] && (m_ctl[1] ? !hitany : hitany);
    cat = (m_ctl[2] && a == '1) || (m_ctl[3] && a[40]) || (m_ctl[4] && !a[40]);
    return tbl || cat;
  endfunction

  function automatic string pick_tag(input logic [47:0] a);
    if (a == '1 && m_ctl[2]) return "R7";
    if (a[40] && m_ctl[3]) return "R8";
    if (!a[40] && m_ctl[4]) return "R9";
    if (!m_ctl[0]) return "R5";
    if (m_ctl[1]) return "R6";
    return "R3";
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = RAW'(idx); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_ctl(input logic [4:0] c);
    wr(0, {27'h0, c}); m_ctl = c;
  endtask

  task automatic set_en(input logic [15:0] e);
    wr(1, {16'h0, e}); m_en = e;
  endtask

  task automatic probe(input logic [47:0] a, input string tag);
    string t;
    logic [IDX_W-1:0] ei;
    logic ea;
    t  = (tag == "") ? pick_tag(a) : tag;
    ei = exp_idx(a);
    ea = exp_acc(a);
    @(negedge clk);
    addr_valid = 1'b1; dst_addr = a;
    @(negedge clk);
    addr_valid = 1'b0; dst_addr = ~a;
    chk("R10 valid", 48'(dec_valid), 48'd1);
    chk({t, " accept"}, 48'(dec_accept), 48'(ea));
    chk({"R11 ", t, " index"}, 48'(dec_index), 48'(ei));
    @(negedge clk);
    chk("R10 valid drop", 48'(dec_valid), 48'd0);
    chk("R10 hold", 48'({dec_accept, dec_index}), 48'({ea, ei}));
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < N; i++) probe(addr_of(i), tag);
    probe(48'h0612_3456_789A, tag);
    probe(48'h0100_5E00_0001, tag);
    probe(48'hFFFF_FFFF_FFFF, tag);
    probe(48'hFFFF_FFFF_FFFE, tag);
    probe(addr_of(0) ^ 48'h1, tag);
  endtask

  initial begin
    m_en = '0; m_ctl = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 48'(dec_valid), 48'd0);
    chk("R1 accept", 48'(dec_accept), 48'd0);
    chk("R1 index", 48'(dec_index), 48'hF);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after", 48'(dec_valid), 48'd0);
    // R1: mask and control cleared, so nothing is accepted
    for (int i = 0; i < N; i++) m_addr[i] = addr_of(i);
    for (int i = 0; i < N; i++) begin
      wr(2 + 2*i, addr_of(i)[47:16]);
      wr(3 + 2*i, {addr_of(i)[15:0], 16'hDEAD ^ 16'(i)});  // R2 low half junk
    end
    probe(addr_of(3), "R1");
    // full control sweep, all entries enabled
    set_en(16'hFFFF);
    for (int c = 0; c < 32; c++) begin
      set_ctl(5'(c));
      sweep("");
    end
    // R4: disabled entries; entry 5 off so duplicate 12 wins (R11)
    set_en(16'hFFFF & ~16'h0220);
    set_ctl(5'b00001); sweep("R4");
    set_ctl(5'b00011); sweep("R4");
    // R2: out-of-range writes ignored, then low half rewritten with other junk
    for (int k = 2 + 2*N; k < 64; k++) wr(k, 32'h0);
    wr(3 + 2*7, {addr_of(7)[15:0], 16'h0000});
    set_en(16'hFFFF);
    set_ctl(5'b00001); sweep("R2");
    // R2: rewrite entry 7 with a different address
    m_addr[7] = 48'h0288_7766_5544;
    wr(2 + 2*7, 32'h0288_7766);
    wr(3 + 2*7, 32'h5544_FFFF);
    probe(48'h0288_7766_5544, "R2");
    probe(addr_of(7), "R2");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule